// File: doc/BRIEF.md
# Clock Level Best-Match Selector

This block searches a small table of available source clock frequencies for the entry that, after division by a whole number, lands closest to a requested serial clock without going over it. Software or a neighbouring controller first loads the table through a write port. It then presents a request frequency, the number of valid levels and a flag that says whether only an exact match is acceptable. A one-cycle start pulse launches the search. When the search ends, a one-cycle done pulse returns the winning index, the source frequency stored there and a success flag.

For each entry the block works out the smallest divider that keeps the output at or below the request. That divider is the entry divided by the request, rounded up. The output is then the entry divided by that divider, rounded down, and the shortfall from the request is the error. Entries are visited in index order, one at a time, by a single shared sequential divider. The search stops early on a zero-error entry. Building the table from a clock controller and programming the chosen divider are left to other logic.

Top module: `clk_level_match`

## Requirements
- R1: After a synchronous reset, busy, done and ok are 0, and best_idx and best_freq are 0.
- R2: For each visited entry F, the divider is ceil(F / request) and the error is request - floor(F / divider). The reported entry is the one with the smallest error among the first level_count entries. best_idx is its 0-based table index and best_freq is its stored value.
- R3: An entry replaces the current best only when its error is strictly smaller, so when two entries tie the lower index is reported.
- R4: The search stops on the first entry whose error is zero and reports success, without visiting later entries. A search that stops at index 0 therefore completes in far fewer cycles than a full-table search.
- R5: When no zero-error entry exists and exact_req is 1, ok is 0. The best entry is still reported on best_idx and best_freq. When exact_req is 0, ok is 1.
- R6: A level_count of 0 gives ok = 0 and best_idx = best_freq = 0, with done on the cycle after start and no search.
- R7: A request of 0 gives ok = 0 and best_idx = best_freq = 0, with done on the cycle after start and no search.
- R8: done is high for exactly one cycle, and busy is 0 in that cycle. ok, best_idx and best_freq hold their values from done until the next accepted start.
- R9: A start pulse while busy is 1 is ignored. The running search finishes with its own operands and produces a single done pulse.
- R10: A level_count larger than MAX_LEVELS is treated as MAX_LEVELS.
- R11: A table entry of 0 produces an output of 0, so its error equals the request and it never beats a non-zero entry with a smaller error.
- R12: A write with tbl_we = 1 stores tbl_wdata at index tbl_waddr, and later searches use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | IDX_W (5) | Table write index |
| tbl_wdata | input | FREQ_W (32) | Frequency value written to the table |
| level_count | input | CNT_W (6) | Number of valid table levels, sampled at start |
| req_freq | input | FREQ_W (32) | Requested output frequency, sampled at start |
| exact_req | input | 1 | 1 = only a zero-error match counts as success |
| start | input | 1 | Launch a search (ignored while busy) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| ok | output | 1 | Search succeeded |
| best_idx | output | IDX_W (5) | Index of the selected entry |
| best_freq | output | FREQ_W (32) | Table value at the selected index |

## Verification
A wrong divider step or a wrong error comparison shows up as the wrong best_idx or best_freq on the done pulse of the search that hits it. Each vector is built so that a neighbouring entry with a slightly different error would win instead. If the running best is corrupted, ties resolve to the later index, and a zero-valued entry or an exact-only request flips ok. A broken early-exit or count clamp leaves the values unchanged but shifts the done pulse by tens to thousands of cycles, so the search latency is compared across searches. Stuck control states show up as a missing or doubled done pulse within one search time.

// File: rtl/clk_level_pkg.sv
package clk_level_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_DIV1,
    ST_DIV2,
    ST_CMP
  } sel_state_t;

endpackage

// File: rtl/clk_level_table.sv
module clk_level_table #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // One write port and one registered read port, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/clk_level_div.sv
module clk_level_div #(
  parameter int W   = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    trial, diff;
  logic          ge;
  logic [W-1:0]  rem_n, quo_n;

  // Restoring division: one quotient bit per cycle.
  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dsr_q};
    ge    = trial >= {1'b0, dsr_q};
    rem_n = ge ? diff[W-1:0] : trial[W-1:0];
    quo_n = {quo_q[W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/clk_level_fsm.sv
module clk_level_fsm
  import clk_level_pkg::*;
#(
  parameter int FREQ_W     = 32,
  parameter int MAX_LEVELS = 32,
  localparam int IDX_W     = $clog2(MAX_LEVELS),
  localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  level_count,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic              exact_req,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [FREQ_W-1:0] rd_data,
  output logic              div_start,
  output logic [FREQ_W-1:0] div_a,
  output logic [FREQ_W-1:0] div_b,
  input  logic              div_done,
  input  logic [FREQ_W-1:0] div_q,
  input  logic [FREQ_W-1:0] div_r,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [IDX_W-1:0]  best_idx,
  output logic [FREQ_W-1:0] best_freq
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_LEVELS);

  sel_state_t        state;
  logic [IDX_W-1:0]  idx_q, last_q, bidx_q, ridx_q;
  logic [FREQ_W-1:0] req_q, ent_q, cur_err, best_err, bfreq_q, rfreq_q;
  logic              ex_q, found_q, done_q, ok_q;

  logic [CNT_W-1:0]  cnt_eff;
  logic [FREQ_W-1:0] ceil_div;
  logic              better, hit, at_end;

  always_comb begin
    cnt_eff  = (level_count > MAX_CNT) ? MAX_CNT : level_count;
    ceil_div = div_q + FREQ_W'(div_r != '0);
    better   = cur_err < best_err;
    hit      = better && (cur_err == '0);
    at_end   = idx_q == last_q;
  end

  // Operand routing into the shared divider.
  always_comb begin
    div_start = 1'b0;
    div_a     = ent_q;
    div_b     = req_q;
    if (state == ST_LOAD) begin
      div_start = 1'b1;
      div_a     = rd_data;
    end else if (state == ST_DIV1 && div_done && ent_q != '0) begin
      div_start = 1'b1;
      div_b     = ceil_div;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      req_q    <= '0;
      ex_q     <= 1'b0;
      ent_q    <= '0;
      cur_err  <= '0;
      best_err <= '1;
      bidx_q   <= '0;
      bfreq_q  <= '0;
      found_q  <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      ridx_q   <= '0;
      rfreq_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            req_q    <= req_freq;
            ex_q     <= exact_req;
            last_q   <= IDX_W'(cnt_eff - 1'b1);
            idx_q    <= '0;
            best_err <= '1;
            found_q  <= 1'b0;
            bidx_q   <= '0;
            bfreq_q  <= '0;
            if (req_freq == '0 || level_count == '0) begin
              done_q  <= 1'b1;
              ok_q    <= 1'b0;
              ridx_q  <= '0;
              rfreq_q <= '0;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_READ: state <= ST_LOAD;
        ST_LOAD: begin
          ent_q <= rd_data;
          state <= ST_DIV1;
        end
        ST_DIV1: begin
          if (div_done) begin
            if (ent_q == '0) begin
              cur_err <= req_q;
              state   <= ST_CMP;
            end else begin
              state <= ST_DIV2;
            end
          end
        end
        ST_DIV2: begin
          if (div_done) begin
            cur_err <= req_q - div_q;
            state   <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (better) begin
            best_err <= cur_err;
            bidx_q   <= idx_q;
            bfreq_q  <= ent_q;
            found_q  <= 1'b1;
          end
          if (hit || at_end) begin
            state   <= ST_IDLE;
            done_q  <= 1'b1;
            ridx_q  <= better ? idx_q : bidx_q;
            rfreq_q <= better ? ent_q : bfreq_q;
            ok_q    <= hit ? 1'b1 : (!ex_q && (found_q || better));
          end else begin
            idx_q <= idx_q + 1'b1;
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr   = idx_q;
  assign busy      = state != ST_IDLE;
  assign done      = done_q;
  assign ok        = ok_q;
  assign best_idx  = ridx_q;
  assign best_freq = rfreq_q;

endmodule

// File: rtl/clk_level_match.sv
module clk_level_match #(
  parameter int FREQ_W     = 32,
  parameter int MAX_LEVELS = 32,
  localparam int IDX_W     = $clog2(MAX_LEVELS),
  localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_waddr,
  input  logic [FREQ_W-1:0] tbl_wdata,
  input  logic [CNT_W-1:0]  level_count,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic              exact_req,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic [IDX_W-1:0]  best_idx,
  output logic [FREQ_W-1:0] best_freq
);

  logic [IDX_W-1:0]  rd_addr;
  logic [FREQ_W-1:0] rd_data;
  logic              div_start, div_done;
  logic [FREQ_W-1:0] div_a, div_b, div_q, div_r;

  clk_level_table #(.DEPTH(MAX_LEVELS), .W(FREQ_W)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  clk_level_div #(.W(FREQ_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .start     (div_start),
    .dividend  (div_a),
    .divisor   (div_b),
    .done      (div_done),
    .quotient  (div_q),
    .remainder (div_r)
  );

  clk_level_fsm #(.FREQ_W(FREQ_W), .MAX_LEVELS(MAX_LEVELS)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .level_count (level_count),
    .req_freq    (req_freq),
    .exact_req   (exact_req),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .div_start   (div_start),
    .div_a       (div_a),
    .div_b       (div_b),
    .div_done    (div_done),
    .div_q       (div_q),
    .div_r       (div_r),
    .busy        (busy),
    .done        (done),
    .ok          (ok),
    .best_idx    (best_idx),
    .best_freq   (best_freq)
  );

endmodule

// File: rtl/clk_level_match_chk.sv
module clk_level_match_chk #(
  parameter int FREQ_W     = 32,
  parameter int MAX_LEVELS = 32,
  localparam int IDX_W     = $clog2(MAX_LEVELS),
  localparam int CNT_W     = $clog2(MAX_LEVELS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CNT_W-1:0]  level_count,
  input logic [FREQ_W-1:0] req_freq,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic [IDX_W-1:0]  best_idx,
  input logic [FREQ_W-1:0] best_freq
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_LEVELS);

  logic [CNT_W-1:0]  cnt_c;
  logic [FREQ_W-1:0] req_c;
  logic [CNT_W-1:0]  lim_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_c <= '0;
      req_c <= '0;
    end else if (start && !busy) begin
      cnt_c <= level_count;
      req_c <= req_freq;
    end
  end

  assign lim_c = (cnt_c > MAX_CNT) ? MAX_CNT : cnt_c;

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && !done) |=> ($stable(ok) && $stable(best_idx) && $stable(best_freq)));

  a_r8_start_reacts: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy || done));

  a_r6_r7_no_search: assert property (@(posedge clk) disable iff (rst)
    (done && (cnt_c == '0 || req_c == '0)) |-> !ok);

  a_r10_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    (done && ok) |-> (CNT_W'(best_idx) < lim_c));

endmodule

bind clk_level_match clk_level_match_chk #(.FREQ_W(FREQ_W), .MAX_LEVELS(MAX_LEVELS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .level_count (level_count),
  .req_freq    (req_freq),
  .busy        (busy),
  .done        (done),
  .ok          (ok),
  .best_idx    (best_idx),
  .best_freq   (best_freq)
);

// File: tb/clk_level_match_bench.sv
module clk_level_match_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_waddr = '0;
  logic [31:0] tbl_wdata = '0;
  logic [5:0]  level_count = '0;
  logic [31:0] req_freq = '0;
  logic        exact_req = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, ok;
  logic [4:0]  best_idx;
  logic [31:0] best_freq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_level_match u_clk_level_match (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .level_count(level_count), .req_freq(req_freq), .exact_req(exact_req), .start(start),
    .busy(busy), .done(done), .ok(ok), .best_idx(best_idx), .best_freq(best_freq)
  );

  typedef struct packed {
    logic [31:0] rq;
    logic        ex;
    logic [5:0]  cnt;
    logic        ok;
    logic [4:0]  idx;
    logic [31:0] fq;
  } vec_t;

  // Table: 100, 96, 120, 75, 0, 120, then 7 in every other slot.
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'd48,   1'b0, 6'd4,  1'b1, 5'd1, 32'd96 },  // R2: second entry exact
    '{32'd50,   1'b0, 6'd4,  1'b1, 5'd0, 32'd100},  // R2: first entry exact
    '{32'd40,   1'b0, 6'd4,  1'b1, 5'd2, 32'd120},  // R2: third entry exact
    '{32'd45,   1'b0, 6'd4,  1'b1, 5'd2, 32'd120},  // R2: closest below, error 5
    '{32'd45,   1'b1, 6'd4,  1'b0, 5'd2, 32'd120},  // R5: exact-only fails, best still reported
    '{32'd45,   1'b0, 6'd6,  1'b1, 5'd2, 32'd120},  // R3 tie with index 5; R11 zero entry
    '{32'd1000, 1'b0, 6'd5,  1'b1, 5'd2, 32'd120},  // R11: zero entry must not win
    '{32'd7,    1'b1, 6'd32, 1'b1, 5'd6, 32'd7  },  // R4 R5: exact hit deep in table
    '{32'd9,    1'b1, 6'd32, 1'b0, 5'd0, 32'd100}   // R5 R3: all error 1 or more, first kept
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_entry(input int a, input logic [31:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 5'(a); tbl_wdata = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // Launch one search and wait for done; also checks the pulse shape (R8).
  task automatic run_search(input logic [31:0] rq, input logic ex, input logic [5:0] cnt,
                            output int cyc);
    @(negedge clk);
    req_freq = rq; exact_req = ex; level_count = cnt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check("R8 done seen", 32'(done), 32'd1);
    check("R8 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", WDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int c0, c32, c63, cfast;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 ok", 32'(ok), 32'd0);
    check("R1 idx", 32'(best_idx), 32'd0);
    check("R1 freq", best_freq, 32'd0);

    for (int i = 0; i < 32; i++) begin
      logic [31:0] v;
      case (i)
        0: v = 32'd100;
        1: v = 32'd96;
        2: v = 32'd120;
        3: v = 32'd75;
        4: v = 32'd0;
        5: v = 32'd120;
        default: v = 32'd7;
      endcase
      write_entry(i, v);
    end

    for (int k = 0; k < NV; k++) begin
      run_search(VECS[k].rq, VECS[k].ex, VECS[k].cnt, c0);
      check($sformatf("vector %0d ok", k), 32'(ok), 32'(VECS[k].ok));
      check($sformatf("vector %0d idx", k), 32'(best_idx), 32'(VECS[k].idx));
      check($sformatf("vector %0d freq", k), best_freq, VECS[k].fq);
    end

    // R8: results hold while idle
    repeat (5) @(negedge clk);
    check("R8 hold idx", 32'(best_idx), 32'd0);
    check("R8 hold freq", best_freq, 32'd100);

    // R6: zero levels
    run_search(32'd48, 1'b0, 6'd0, c0);
    check("R6 ok", 32'(ok), 32'd0);
    check("R6 idx", 32'(best_idx), 32'd0);
    check("R6 freq", best_freq, 32'd0);
    check("R6 latency", 32'(c0), 32'd1);

    // R7: zero request
    run_search(32'd0, 1'b0, 6'd4, c0);
    check("R7 ok", 32'(ok), 32'd0);
    check("R7 freq", best_freq, 32'd0);
    check("R7 latency", 32'(c0), 32'd1);

    // R10: count above the table size behaves like a full table
    run_search(32'd9, 1'b1, 6'd32, c32);
    run_search(32'd9, 1'b1, 6'd63, c63);
    check("R10 latency", 32'(c63), 32'(c32));
    check("R10 idx", 32'(best_idx), 32'd0);
    check("R10 ok", 32'(ok), 32'd0);

    // R4: exact hit at index 0 stops the search early
    run_search(32'd100, 1'b0, 6'd32, cfast);
    check("R4 idx", 32'(best_idx), 32'd0);
    check("R4 early stop", 32'(cfast * 8 < c32), 32'd1);

    // R12: rewrite an entry and find it
    write_entry(3, 32'd45);
    run_search(32'd45, 1'b1, 6'd4, c0);
    check("R12 ok", 32'(ok), 32'd1);
    check("R12 idx", 32'(best_idx), 32'd3);
    check("R12 freq", best_freq, 32'd45);

    // R9: start while busy is ignored
    begin
      int pulses = 0;
      @(negedge clk);
      req_freq = 32'd48; exact_req = 1'b0; level_count = 6'd4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      req_freq = 32'd0; level_count = 6'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 600; t++) begin
        if (done) pulses++;
        @(negedge clk);
      end
      check("R9 single done", 32'(pulses), 32'd1);
      check("R9 ok", 32'(ok), 32'd1);
      check("R9 idx", 32'(best_idx), 32'd1);
      check("R9 freq", best_freq, 32'd96);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule